// File: doc/BRIEF.md
# Indirect Masked Table Memory Port

This block is a small register file through which a host reaches two internal memories that are not directly mapped: a table RAM whose entries are 128 bits wide, and a byte-wide buffer RAM. The host stages up to four 32-bit data words and four 32-bit bit-enable masks. It then writes a command word that holds a direction bit, a memory-select bit and an address. That write starts one transfer.

On a table write, only the entry bits whose mask bit is 1 are replaced. This lets software update a single 16-bit channel record packed inside a shared entry without a read-modify-write of its own. On a read, the data words are loaded from the addressed location. When the transfer ends, a completion flag is set. The flag stays set until software clears it. While a transfer is in flight, any further command is dropped.

Top module: `ind_mem_port`

## Requirements
- R1: After reset, every host register reads 0: data words (offsets 0-3), mask words (offsets 4-7), command (offset 8) and control/status (offset 9).
- R2: Data word k is written and read at offset k, and mask word k at offset 4+k. A write followed by a read returns the written value.
- R3: A write to offset 8 while idle starts a transfer. Status bit 1 (busy) reads 1 after the accepting clock edge. Status bit 0 (done) reads 1 from the second clock edge after the accepting edge, and busy then reads 0.
- R4: A table write (command bit 31 = 1, bit 30 = 0, entry address in bits 7:0) replaces bit i of word k of the entry only where bit i of mask word k is 1. Bits with a 0 mask keep their old value.
- R5: A table read (bit 31 = 0, bit 30 = 0) loads all four data words from the entry, with word k of the entry going to data word k, before done is raised.
- R6: With bit 30 = 1 the buffer RAM is used at byte address bits 7:0. A write stores bits 7:0 of data word 0, and the masks are not applied. A read sets data word 0 to the zero-extended byte and leaves data words 1-3 unchanged. The table is not touched.
- R7: Done is sticky. Writing offset 9 with bit 0 = 0 clears it, and writing bit 0 = 1 leaves it unchanged.
- R8: If a host clear of done and the completion of a transfer fall on the same edge, done ends up 1.
- R9: A write to offset 8 while busy is ignored. The command register keeps the accepted command, and neither memory is changed by the ignored command.
- R10: A table address at or above the table depth (144 entries, 0x00-0x8F) discards writes. A read of such an address loads zeros into all four data words, and done is still raised.
- R11: A channel record n of an allocation table at base B lies in entry B + n/8, word (n mod 8)/2, halfword n mod 2. A masked write covering only that halfword leaves the other seven records of the entry intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 4 | Host register word offset |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data (combinational on reg_addr_i) |

## Verification
Two events can meet on one clock edge: the end of a transfer, which sets done and may load the data words, and a host write that clears done or issues another command. The bench issues a clear exactly two edges after a command, so that it lands on the completion edge, and judges the case by done still reading 1. It also issues a second command on the edge right after the first, while the port is busy. That case is judged by the command register readback and by reading back the entry the ignored command would have written.

// File: rtl/ind_mem_pkg.sv
package ind_mem_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NW     = 4;
  localparam int unsigned EW     = DW * NW;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] OFF_CMD  = 4'd8;
  localparam logic [REG_AW-1:0] OFF_CTRL = 4'd9;

  localparam int unsigned CMD_WR_BIT  = 31;
  localparam int unsigned CMD_BUF_BIT = 30;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/imp_regs.sv
module imp_regs
  import ind_mem_pkg::*;
#(
  parameter int unsigned CA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              busy_i,
  input  logic              done_set_i,
  input  logic              load_en_i,
  input  logic              load_buf_i,
  input  logic [EW-1:0]     load_data_i,
  output logic [DW-1:0]     rdata_o,
  output logic [EW-1:0]     data_o,
  output logic [EW-1:0]     mask_o,
  output logic [CA_W-1:0]   cmd_addr_o,
  output logic              cmd_wr_o,
  output logic              cmd_buf_o,
  output logic              cmd_start_o
);
  logic [NW-1:0][DW-1:0] data_q, mask_q;
  logic [DW-1:0]         cmd_q;
  logic                  done_q;
  logic                  cmd_hit, clr_hit;

  assign cmd_hit     = wr_i && (addr_i == OFF_CMD);
  assign clr_hit     = wr_i && (addr_i == OFF_CTRL) && !wdata_i[0];
  assign cmd_start_o = cmd_hit && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      mask_q <= '0;
      cmd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_i) begin
        for (int w = 0; w < NW; w++) begin
          if (addr_i == REG_AW'(w))      data_q[w] <= wdata_i;
          if (addr_i == REG_AW'(NW + w)) mask_q[w] <= wdata_i;
        end
      end
      if (cmd_start_o) cmd_q <= wdata_i;
      // transfer load overrides a host write in the same cycle
      if (load_en_i) begin
        if (load_buf_i) data_q[0] <= {{(DW-8){1'b0}}, load_data_i[7:0]};
        else            data_q    <= load_data_i;
      end
      if (done_set_i)   done_q <= 1'b1;
      else if (clr_hit) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[3:2] == 2'b00)      rdata_o = data_q[addr_i[1:0]];
    else if (addr_i[3:2] == 2'b01) rdata_o = mask_q[addr_i[1:0]];
    else if (addr_i == OFF_CMD)    rdata_o = cmd_q;
    else if (addr_i == OFF_CTRL)   rdata_o = {{(DW-2){1'b0}}, busy_i, done_q};
  end

  assign data_o     = data_q;
  assign mask_o     = mask_q;
  assign cmd_addr_o = cmd_q[CA_W-1:0];
  assign cmd_wr_o   = cmd_q[CMD_WR_BIT];
  assign cmd_buf_o  = cmd_q[CMD_BUF_BIT];

  // R9
  ign_busy_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit && busy_i) |=> $stable(cmd_q));
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> done_q);
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_hit) |=> done_q);
endmodule

// File: rtl/imp_seq.sv
module imp_seq
  import ind_mem_pkg::*;
#(
  parameter int unsigned TBL_AW = 8,
  parameter int unsigned BUF_AW = 8,
  parameter int unsigned CA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmd_wr_i,
  input  logic              cmd_buf_i,
  input  logic [CA_W-1:0]   cmd_addr_i,
  output logic              busy_o,
  output logic              done_set_o,
  output logic              load_en_o,
  output logic              load_buf_o,
  output logic              tbl_we_o,
  output logic              tbl_re_o,
  output logic              buf_we_o,
  output logic              buf_re_o,
  output logic [TBL_AW-1:0] tbl_addr_o,
  output logic [BUF_AW-1:0] buf_addr_o
);
  seq_state_e state_q, state_d;
  logic       acc;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign acc        = (state_q == ST_ACCESS);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_set_o = (state_q == ST_FINISH);
  assign load_en_o  = (state_q == ST_FINISH) && !cmd_wr_i;
  assign load_buf_o = cmd_buf_i;
  assign tbl_we_o   = acc &&  cmd_wr_i && !cmd_buf_i;
  assign tbl_re_o   = acc && !cmd_wr_i && !cmd_buf_i;
  assign buf_we_o   = acc &&  cmd_wr_i &&  cmd_buf_i;
  assign buf_re_o   = acc && !cmd_wr_i &&  cmd_buf_i;
  assign tbl_addr_o = cmd_addr_i[TBL_AW-1:0];
  assign buf_addr_o = cmd_addr_i[BUF_AW-1:0];

  // R3
  start_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (state_q == ST_ACCESS));
  // R3
  access_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACCESS) |=> (state_q == ST_FINISH));
  // R6
  one_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tbl_we_o, tbl_re_o, buf_we_o, buf_re_o}));
endmodule

// File: rtl/imp_tbl_ram.sv
module imp_tbl_ram
  import ind_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [EW-1:0] wmask_i,
  output logic [EW-1:0] rdata_o
);
  logic in_range;
  assign in_range = (int'(addr_i) < int'(DEPTH));

  for (genvar w = 0; w < NW; w++) begin : g_lane
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] d, m;
    assign d = wdata_i[w*DW +: DW];
    assign m = wmask_i[w*DW +: DW];

    always_ff @(posedge clk_i) begin
      if (we_i && in_range) mem[addr_i] <= (mem[addr_i] & ~m) | (d & m);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rdata_o[w*DW +: DW] <= '0;
      else if (re_i) rdata_o[w*DW +: DW] <= in_range ? mem[addr_i] : '0;
    end
  end

  // R10
  oor_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !in_range) |=> (rdata_o == '0));
endmodule

// File: rtl/imp_buf_ram.sv
module imp_buf_ram #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
  import ind_mem_pkg::*;
#(
  parameter int unsigned TBL_DEPTH = 144,
  parameter int unsigned BUF_AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o
);
  localparam int unsigned TBL_AW = $clog2(TBL_DEPTH);
  localparam int unsigned CA_W   = (TBL_AW > BUF_AW) ? TBL_AW : BUF_AW;

  logic [EW-1:0]     data, mask, tbl_rdata, load_data;
  logic [CA_W-1:0]   cmd_addr;
  logic              cmd_wr, cmd_buf, cmd_start;
  logic              busy, done_set, load_en, load_buf;
  logic              tbl_we, tbl_re, buf_we, buf_re;
  logic [TBL_AW-1:0] tbl_addr;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0]        buf_rdata;

  assign load_data = load_buf ? {{(EW-8){1'b0}}, buf_rdata} : tbl_rdata;

  imp_regs #(.CA_W(CA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .done_set_i(done_set),
    .load_en_i(load_en), .load_buf_i(load_buf), .load_data_i(load_data),
    .rdata_o(reg_rdata_o), .data_o(data), .mask_o(mask),
    .cmd_addr_o(cmd_addr), .cmd_wr_o(cmd_wr), .cmd_buf_o(cmd_buf),
    .cmd_start_o(cmd_start)
  );

  imp_seq #(.TBL_AW(TBL_AW), .BUF_AW(BUF_AW), .CA_W(CA_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(cmd_start), .cmd_wr_i(cmd_wr), .cmd_buf_i(cmd_buf),
    .cmd_addr_i(cmd_addr),
    .busy_o(busy), .done_set_o(done_set),
    .load_en_o(load_en), .load_buf_o(load_buf),
    .tbl_we_o(tbl_we), .tbl_re_o(tbl_re), .buf_we_o(buf_we), .buf_re_o(buf_re),
    .tbl_addr_o(tbl_addr), .buf_addr_o(buf_addr)
  );

  imp_tbl_ram #(.DEPTH(TBL_DEPTH), .AW(TBL_AW)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .re_i(tbl_re), .addr_i(tbl_addr),
    .wdata_i(data), .wmask_i(mask), .rdata_o(tbl_rdata)
  );

  imp_buf_ram #(.AW(BUF_AW)) u_buf (
    .clk_i, .rst_ni,
    .we_i(buf_we), .re_i(buf_re), .addr_i(buf_addr),
    .wdata_i(data[7:0]), .rdata_o(buf_rdata)
  );
endmodule

// File: tb/ind_mem_port_bench.sv
`timescale 1ns/1ps
module ind_mem_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ind_mem_port u_ind_mem_port (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  typedef struct packed {
    logic [7:0]   a;
    logic [127:0] d;
    logic [127:0] m;
    logic [127:0] e;
  } vec_t;

  localparam logic [127:0] ONES = {128{1'b1}};
  localparam vec_t VECS [6] = '{
    '{8'h05, 128'h33333333_22222222_11111111_00000000, ONES,
             128'h33333333_22222222_11111111_00000000},
    '{8'h05, ONES, 128'h000000FF_00000000_F0F0F0F0_0000000F,
             128'h333333FF_22222222_F1F1F1F1_0000000F},
    '{8'h8F, 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, ONES,
             128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF},
    '{8'h00, 128'hA5A5A5A5_5A5A5A5A_12345678_9ABCDEF0, ONES,
             128'hA5A5A5A5_5A5A5A5A_12345678_9ABCDEF0},
    '{8'h00, ONES, 128'h0,
             128'hA5A5A5A5_5A5A5A5A_12345678_9ABCDEF0},
    '{8'h8F, 128'h0, 128'hFFFFFFFF_00000000_00000000_00000000,
             128'h00000000_CAFEF00D_01234567_89ABCDEF}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_pair(input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = d0;
    @(negedge clk);
    reg_wdata = d1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic get_entry(output logic [127:0] e);
    logic [31:0] t;
    for (int w = 0; w < 4; w++) begin
      rd(4'(w), t);
      e[w*32 +: 32] = t;
    end
  endtask

  task automatic put_regs(input logic [127:0] d, input logic [127:0] m);
    for (int w = 0; w < 4; w++) begin
      wr(4'(w), d[w*32 +: 32]);
      wr(4'(4 + w), m[w*32 +: 32]);
    end
  endtask

  task automatic wait_done();
    logic [31:0] t;
    t = '0;
    for (int i = 0; i < 50; i++) begin
      rd(4'd9, t);
      if (t[0]) break;
      @(negedge clk);
    end
    if (!t[0]) chk(1'b0, "R3 completion timeout", 128'(t), 128'h1);
  endtask

  task automatic run_cmd(input logic [31:0] c);
    wr(4'd9, 32'h0);
    wr(4'd8, c);
    wait_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0]  t, t2;
    logic [127:0] e, p, hm, hd;
    bit           bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bad = 0;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), t);
      if (t !== 32'h0) bad = 1;
    end
    chk(!bad, "R1 reset registers", 128'(bad), 128'h0);

    // R2 register readback
    wr(4'd1, 32'h13579BDF);
    wr(4'd6, 32'h2468ACE0);
    rd(4'd1, t);  chk(t === 32'h13579BDF, "R2 data word 1", 128'(t), 128'h13579BDF);
    rd(4'd6, t);  chk(t === 32'h2468ACE0, "R2 mask word 2", 128'(t), 128'h2468ACE0);

    // R3 cycle timing of a transfer
    wr(4'd8, 32'h8000_0070);
    rd(4'd9, t);
    chk(t[1:0] === 2'b10, "R3 busy after accept", 128'(t[1:0]), 128'h2);
    @(negedge clk); rd(4'd9, t);
    chk(t[1:0] === 2'b10, "R3 still busy one edge later", 128'(t[1:0]), 128'h2);
    @(negedge clk); rd(4'd9, t);
    chk(t[1:0] === 2'b01, "R3 done at second edge", 128'(t[1:0]), 128'h1);

    // R7 sticky flag
    wr(4'd9, 32'h1); rd(4'd9, t);
    chk(t[0] === 1'b1, "R7 write 1 keeps done", 128'(t[0]), 128'h1);
    wr(4'd9, 32'h0); rd(4'd9, t);
    chk(t[0] === 1'b0, "R7 write 0 clears done", 128'(t[0]), 128'h0);

    // R4 R5 vector walk: masked write then full read
    for (int i = 0; i < 6; i++) begin
      put_regs(VECS[i].d, VECS[i].m);
      run_cmd(32'h8000_0000 | 32'(VECS[i].a));
      put_regs(ONES, 128'h0);
      run_cmd(32'(VECS[i].a));
      get_entry(e);
      chk(e === VECS[i].e, $sformatf("R4 R5 vector %0d", i), e, VECS[i].e);
    end

    // R8 clear lands on completion edge
    wr(4'd9, 32'h0);
    wr(4'd8, 32'h0000_0005);
    wr(4'd9, 32'h0);
    rd(4'd9, t);
    chk(t[0] === 1'b1, "R8 set wins over clear", 128'(t[0]), 128'h1);

    // R9 command while busy
    put_regs(128'h0, ONES);
    wr(4'd9, 32'h0);
    wr_pair(32'h0000_0005, 32'h8000_0000);
    wait_done();
    rd(4'd8, t);
    chk(t === 32'h0000_0005, "R9 command register kept", 128'(t), 128'h5);
    run_cmd(32'h0000_0000);
    get_entry(e);
    chk(e === VECS[4].e, "R9 ignored write left entry 0", e, VECS[4].e);

    // R6 buffer RAM
    put_regs(128'h0_00000000_00000077_FFFFFF5C, 128'h0);
    run_cmd(32'hC000_0005);
    wr(4'd0, 32'h0);
    run_cmd(32'h4000_0005);
    rd(4'd0, t);  chk(t === 32'h0000005C, "R6 buffer byte read", 128'(t), 128'h5C);
    rd(4'd1, t2); chk(t2 === 32'h00000077, "R6 word 1 unchanged", 128'(t2), 128'h77);
    run_cmd(32'h0000_0005);
    get_entry(e);
    chk(e === VECS[1].e, "R6 table entry untouched", e, VECS[1].e);

    // R10 out-of-range table address
    put_regs(ONES, ONES);
    run_cmd(32'h8000_0090);
    run_cmd(32'h0000_0090);
    get_entry(e);
    chk(e === 128'h0, "R10 out-of-range read gives zero", e, 128'h0);
    run_cmd(32'h0000_008F);
    get_entry(e);
    chk(e === VECS[5].e, "R10 last entry intact", e, VECS[5].e);

    // R11 channel record inside allocation entry
    for (int k = 0; k < 2; k++) begin
      int n, base, ent, pos;
      n    = (k == 0) ? 11 : 4;
      base = (k == 0) ? 8'h80 : 8'h88;
      ent  = base + n / 8;
      pos  = ((n % 8) / 2) * 32 + (n % 2) * 16;
      p    = 128'h11112222_33334444_55556666_77778888;
      put_regs(p, ONES);
      run_cmd(32'h8000_0000 | 32'(ent));
      hm = 128'hFFFF << pos;
      hd = 128'hBEEF << pos;
      put_regs(hd | ~hm, hm);
      run_cmd(32'h8000_0000 | 32'(ent));
      run_cmd(32'(ent));
      get_entry(e);
      chk(e === ((p & ~hm) | hd), $sformatf("R11 record %0d", n), e, (p & ~hm) | hd);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule